// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core that uses overlapping register windows. Software addresses 32 registers. Numbers 0–7 are the globals, 8–15 the outgoing registers, 16–23 the locals and 24–31 the incoming registers. Behind that view sits a ring of `NWIN` windows. The globals are shared by every window, and each window owns eight private locals. The outgoing registers of window w are the same storage as the incoming registers of window (w−1) mod `NWIN`, so values a caller places in its outgoing registers appear, with no copying, as the callee's incoming registers after a save.

A current window pointer selects the visible window. A save command steps the pointer down by one and a restore command steps it up by one, both modulo `NWIN`. A mask holds one invalid flag per window. When a save or restore would land on an invalid window, the pointer stays where it is and the block emits a one-cycle trap pulse that says whether the failure was an overflow or an underflow. Software may load the pointer and the mask directly. The file has two combinational read ports and one write port that takes effect at the clock edge.

Top module: `win_regfile`

## Requirements
- R1: After reset the pointer is `NWIN`−1, the mask has only bit 0 set (window 0 invalid), the trap output is low and every register reads zero.
- R2: Register 0 reads as zero on both read ports in every window, and writes to it have no effect.
- R3: A save whose target window (pointer−1 mod `NWIN`) is valid loads that target into the pointer at the next clock edge, wrapping from 0 to `NWIN`−1.
- R4: A restore whose target window (pointer+1 mod `NWIN`) is valid loads that target at the next clock edge, wrapping from `NWIN`−1 to 0.
- R5: A save whose target has its mask bit set to 1 leaves the pointer unchanged and raises `trap_valid` for exactly the following cycle, with `trap_kind` = 0 (overflow).
- R6: A restore whose target has its mask bit set to 1 leaves the pointer unchanged and raises `trap_valid` for the following cycle, with `trap_kind` = 1 (underflow).
- R7: Registers 1–7 name the same storage in every window.
- R8: Registers 16–23 of each window are private to that window and survive save and restore of other windows.
- R9: Registers 8–15 of window w are the same storage as registers 24–31 of window (w−1) mod `NWIN`, in the same order.
- R10: Reads and writes issued in the same cycle as a save or restore use the old pointer. A read of the register being written in that cycle returns the value held before the write.
- R11: A pointer load takes effect at the next edge and cancels any save or restore in the same cycle, with no trap. A mask load takes effect at the next edge, and a save or restore in the same cycle is checked against the old mask.
- R12: When save and restore are requested together, only the save acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Architected index, read port A |
| rd_a_data | output | XLEN | Read data A (combinational) |
| rd_b_idx | input | 5 | Architected index, read port B |
| rd_b_data | output | XLEN | Read data B (combinational) |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Architected index for the write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Step the window down |
| restore_req | input | 1 | Step the window up |
| ptr_wr_en | input | 1 | Load the window pointer |
| ptr_wr_data | input | log2(NWIN) | New pointer value |
| mask_wr_en | input | 1 | Load the invalid mask |
| mask_wr_data | input | NWIN | New mask value |
| cur_ptr | output | log2(NWIN) | Current window pointer |
| inv_mask | output | NWIN | Invalid-window mask |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_kind | output | 1 | 0 = overflow, 1 = underflow |

## Verification
The bench drives the pointer across both wrap points. A design with the wrong modulo arithmetic would jump to a window outside the ring or fail to wrap. It then runs saves until the window marked invalid is the target, and restores until the same happens from the other side. A block that moved the pointer anyway, or reported the wrong trap kind, would show it at the ports. Values are written through the outgoing registers and read back through the incoming registers one window down, and locals are checked across save and restore, which catches aliasing in the wrong direction and windows that share locals. Same-cycle collisions are also covered: a write with a save, a read of a register being written, a pointer load with a trapping save, a mask load with a save, and save with restore. These expose a design that uses the new pointer too early or gets the priority backwards.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned ARCH_IDX_W = 5;
  localparam int unsigned BANK_SZ    = 8;

  typedef enum logic {
    TRAP_OVERFLOW  = 1'b0,
    TRAP_UNDERFLOW = 1'b1
  } trap_kind_e;

  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_group_e;
endpackage

// File: rtl/wrf_addr_map.sv
module wrf_addr_map #(
  parameter int unsigned NWIN = 8
) (
  input  logic [$clog2(NWIN)-1:0]                ptr,
  input  logic [wrf_pkg::ARCH_IDX_W-1:0]         arch_idx,
  output logic [$clog2(8+16*NWIN)-1:0]           phys_idx
);
  import wrf_pkg::*;

  localparam int unsigned PTRW  = $clog2(NWIN);
  localparam int unsigned PHYS  = 8 + 16 * NWIN;
  localparam int unsigned PIDXW = $clog2(PHYS);

  logic [PTRW-1:0]  caller_win;
  logic [2:0]       slot;
  reg_group_e       grp;
  logic [PIDXW-1:0] base;

  assign caller_win = ptr - 1'b1;
  assign slot       = arch_idx[2:0];
  assign grp        = reg_group_e'(arch_idx[4:3]);
  assign base       = PIDXW'(BANK_SZ);

  // Windowed area: per window 16 entries, locals first, then the incoming block.
  always_comb begin
    unique case (grp)
      GRP_GLOBAL: phys_idx = PIDXW'(slot);
      GRP_OUT:    phys_idx = base + PIDXW'({caller_win, 1'b1, slot});
      GRP_LOCAL:  phys_idx = base + PIDXW'({ptr, 1'b0, slot});
      default:    phys_idx = base + PIDXW'({ptr, 1'b1, slot});
    endcase
  end
endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned DEPTH  = 136,
  parameter int unsigned NRD    = 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                we,
  input  logic [$clog2(DEPTH)-1:0]            waddr,
  input  logic [XLEN-1:0]                     wdata,
  input  logic [NRD-1:0][$clog2(DEPTH)-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0]            rdata
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [XLEN-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [AW-1:0] a;
    assign a        = raddr[p];
    assign rdata[p] = mem[a];
  end
endmodule

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
  parameter int unsigned NWIN = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    save_req,
  input  logic                    restore_req,
  input  logic                    ptr_wr_en,
  input  logic [$clog2(NWIN)-1:0] ptr_wr_data,
  input  logic                    mask_wr_en,
  input  logic [NWIN-1:0]         mask_wr_data,
  output logic [$clog2(NWIN)-1:0] cur_ptr,
  output logic [NWIN-1:0]         inv_mask,
  output logic                    trap_valid,
  output logic                    trap_kind
);
  import wrf_pkg::*;

  localparam int unsigned PTRW = $clog2(NWIN);
  localparam logic [PTRW-1:0] PTR_RST  = PTRW'(NWIN - 1);
  localparam logic [NWIN-1:0] MASK_RST = NWIN'(1);

  logic [PTRW-1:0] ptr_q, ptr_d;
  logic [NWIN-1:0] mask_q, mask_d;
  logic            trap_q, trap_d;
  trap_kind_e      kind_q, kind_d;

  logic [PTRW-1:0] down_tgt, up_tgt;
  logic            down_bad, up_bad;

  assign down_tgt = ptr_q - 1'b1;
  assign up_tgt   = ptr_q + 1'b1;
  assign down_bad = mask_q[down_tgt];
  assign up_bad   = mask_q[up_tgt];

  always_comb begin
    ptr_d  = ptr_q;
    trap_d = 1'b0;
    kind_d = kind_q;
    if (ptr_wr_en) begin
      ptr_d = ptr_wr_data;
    end else if (save_req) begin
      if (down_bad) begin
        trap_d = 1'b1;
        kind_d = TRAP_OVERFLOW;
      end else begin
        ptr_d = down_tgt;
      end
    end else if (restore_req) begin
      if (up_bad) begin
        trap_d = 1'b1;
        kind_d = TRAP_UNDERFLOW;
      end else begin
        ptr_d = up_tgt;
      end
    end
  end

  assign mask_d = mask_wr_en ? mask_wr_data : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= PTR_RST;
      mask_q <= MASK_RST;
      trap_q <= 1'b0;
      kind_q <= TRAP_OVERFLOW;
    end else begin
      ptr_q  <= ptr_d;
      mask_q <= mask_d;
      trap_q <= trap_d;
      kind_q <= kind_d;
    end
  end

  assign cur_ptr    = ptr_q;
  assign inv_mask   = mask_q;
  assign trap_valid = trap_q;
  assign trap_kind  = kind_q;
endmodule

// File: rtl/win_regfile.sv
module win_regfile #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              rd_a_idx,
  output logic [XLEN-1:0]         rd_a_data,
  input  logic [4:0]              rd_b_idx,
  output logic [XLEN-1:0]         rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_idx,
  input  logic [XLEN-1:0]         wr_data,
  input  logic                    save_req,
  input  logic                    restore_req,
  input  logic                    ptr_wr_en,
  input  logic [$clog2(NWIN)-1:0] ptr_wr_data,
  input  logic                    mask_wr_en,
  input  logic [NWIN-1:0]         mask_wr_data,
  output logic [$clog2(NWIN)-1:0] cur_ptr,
  output logic [NWIN-1:0]         inv_mask,
  output logic                    trap_valid,
  output logic                    trap_kind
);
  localparam int unsigned PHYS  = 8 + 16 * NWIN;
  localparam int unsigned PIDXW = $clog2(PHYS);
  localparam int unsigned NPORT = 3;  // two reads, one write

  logic [NPORT-1:0][4:0]       arch_idx;
  logic [NPORT-1:0][PIDXW-1:0] phys_idx;
  logic [1:0][PIDXW-1:0]       rd_phys;
  logic [1:0][XLEN-1:0]        rd_raw;
  logic                        wr_go;

  assign arch_idx[0] = rd_a_idx;
  assign arch_idx[1] = rd_b_idx;
  assign arch_idx[2] = wr_idx;

  wrf_window_ctl #(.NWIN(NWIN)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .save_req     (save_req),
    .restore_req  (restore_req),
    .ptr_wr_en    (ptr_wr_en),
    .ptr_wr_data  (ptr_wr_data),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .cur_ptr      (cur_ptr),
    .inv_mask     (inv_mask),
    .trap_valid   (trap_valid),
    .trap_kind    (trap_kind)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_addr_map #(.NWIN(NWIN)) u_map (
      .ptr      (cur_ptr),
      .arch_idx (arch_idx[p]),
      .phys_idx (phys_idx[p])
    );
  end

  assign rd_phys[0] = phys_idx[0];
  assign rd_phys[1] = phys_idx[1];
  assign wr_go      = wr_en && (wr_idx != 5'd0);

  wrf_storage #(.XLEN(XLEN), .DEPTH(PHYS), .NRD(2)) u_mem (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (phys_idx[2]),
    .wdata (wr_data),
    .raddr (rd_phys),
    .rdata (rd_raw)
  );

  assign rd_a_data = (rd_a_idx == 5'd0) ? '0 : rd_raw[0];
  assign rd_b_data = (rd_b_idx == 5'd0) ? '0 : rd_raw[1];
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int unsigned NWIN = 8,
  parameter int unsigned XLEN = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [4:0]              rd_a_idx,
  input logic [XLEN-1:0]         rd_a_data,
  input logic [4:0]              rd_b_idx,
  input logic [XLEN-1:0]         rd_b_data,
  input logic                    save_req,
  input logic                    restore_req,
  input logic                    ptr_wr_en,
  input logic [$clog2(NWIN)-1:0] ptr_wr_data,
  input logic [$clog2(NWIN)-1:0] cur_ptr,
  input logic [NWIN-1:0]         inv_mask,
  input logic                    trap_valid,
  input logic                    trap_kind
);
  localparam int unsigned PTRW = $clog2(NWIN);
  logic [PTRW-1:0] dn, up;
  assign dn = cur_ptr - 1'b1;
  assign up = cur_ptr + 1'b1;

  p_zero_a_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
  p_zero_b_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
  p_save_move_r3: assert property (@(posedge clk) disable iff (rst)
    (save_req && !ptr_wr_en && !inv_mask[dn]) |=> (cur_ptr == $past(dn)) && !trap_valid);
  p_restore_move_r4: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !save_req && !ptr_wr_en && !inv_mask[up]) |=> (cur_ptr == $past(up)) && !trap_valid);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (save_req && !ptr_wr_en && inv_mask[dn]) |=> trap_valid && !trap_kind && $stable(cur_ptr));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !save_req && !ptr_wr_en && inv_mask[up]) |=> trap_valid && trap_kind && $stable(cur_ptr));
  p_ptr_load_r11: assert property (@(posedge clk) disable iff (rst)
    ptr_wr_en |=> (cur_ptr == $past(ptr_wr_data)) && !trap_valid);
  p_ptr_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!ptr_wr_en && !save_req && !restore_req) |=> $stable(cur_ptr) && !trap_valid);
endmodule

bind win_regfile wrf_checker #(.NWIN(NWIN), .XLEN(XLEN)) u_wrf_checker (
  .clk         (clk),
  .rst         (rst),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .rd_b_idx    (rd_b_idx),
  .rd_b_data   (rd_b_data),
  .save_req    (save_req),
  .restore_req (restore_req),
  .ptr_wr_en   (ptr_wr_en),
  .ptr_wr_data (ptr_wr_data),
  .cur_ptr     (cur_ptr),
  .inv_mask    (inv_mask),
  .trap_valid  (trap_valid),
  .trap_kind   (trap_kind)
);

// File: tb/test_win_regfile.sv
module test_win_regfile;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 0, save_req = 0, restore_req = 0, ptr_wr_en = 0, mask_wr_en = 0;
  logic [2:0]  ptr_wr_data = '0, cur_ptr;
  logic [7:0]  mask_wr_data = '0, inv_mask;
  logic        trap_valid, trap_kind;

  int checks = 0;
  int errors = 0;

  // behavioural model
  logic [31:0] m_glob [8];
  logic [31:0] m_loc  [NW][8];
  logic [31:0] m_in   [NW][8];
  int          m_ptr;
  logic [7:0]  m_mask;
  bit          m_trap;
  bit          m_kind;

  always #5 clk = ~clk;

  win_regfile i_win_regfile (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .ptr_wr_en(ptr_wr_en), .ptr_wr_data(ptr_wr_data),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .cur_ptr(cur_ptr), .inv_mask(inv_mask),
    .trap_valid(trap_valid), .trap_kind(trap_kind)
  );

  function automatic logic [31:0] mread(int w, int r);
    if (r == 0)       return '0;
    else if (r < 8)   return m_glob[r];
    else if (r < 16)  return m_in[(w + NW - 1) % NW][r - 8];
    else if (r < 24)  return m_loc[w][r - 16];
    else              return m_in[w][r - 24];
  endfunction

  task automatic mwrite(int w, int r, logic [31:0] v);
    if (r == 0)       ;
    else if (r < 8)   m_glob[r] = v;
    else if (r < 16)  m_in[(w + NW - 1) % NW][r - 8] = v;
    else if (r < 24)  m_loc[w][r - 16] = v;
    else              m_in[w][r - 24] = v;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_glob[i] = '0;
    for (int w = 0; w < NW; w++)
      for (int i = 0; i < 8; i++) begin m_loc[w][i] = '0; m_in[w][i] = '0; end
    m_ptr = NW - 1; m_mask = 8'h01; m_trap = 0; m_kind = 0;
  endtask

  task automatic model_step();
    int t;
    if (wr_en) mwrite(m_ptr, int'(wr_idx), wr_data);
    m_trap = 0;
    if (ptr_wr_en) m_ptr = int'(ptr_wr_data);
    else if (save_req) begin
      t = (m_ptr + NW - 1) % NW;
      if (m_mask[t]) begin m_trap = 1; m_kind = 0; end else m_ptr = t;
    end else if (restore_req) begin
      t = (m_ptr + 1) % NW;
      if (m_mask[t]) begin m_trap = 1; m_kind = 1; end else m_ptr = t;
    end
    if (mask_wr_en) m_mask = mask_wr_data;
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs set after a falling edge by the caller
  task automatic cyc(string tag);
    #2;
    check(tag, "rd_a", rd_a_data, mread(m_ptr, int'(rd_a_idx)));
    check(tag, "rd_b", rd_b_data, mread(m_ptr, int'(rd_b_idx)));
    @(posedge clk);
    model_step();
    #1;
    check(tag, "cur_ptr", 32'(cur_ptr), 32'(m_ptr));
    check(tag, "inv_mask", 32'(inv_mask), 32'(m_mask));
    check(tag, "trap_valid", 32'(trap_valid), 32'(m_trap));
    if (m_trap) check(tag, "trap_kind", 32'(trap_kind), 32'(m_kind));
    @(negedge clk);
    wr_en = 0; save_req = 0; restore_req = 0; ptr_wr_en = 0; mask_wr_en = 0;
  endtask

  task automatic wr(int r, logic [31:0] v, string tag);
    wr_en = 1; wr_idx = 5'(r); wr_data = v; cyc(tag);
  endtask

  task automatic rd(int a, int b, string tag);
    rd_a_idx = 5'(a); rd_b_idx = 5'(b); cyc(tag);
  endtask

  task automatic sv(string tag);  save_req = 1;    cyc(tag); endtask
  task automatic rs(string tag);  restore_req = 1; cyc(tag); endtask

  task automatic read_all(string tag);
    for (int r = 0; r < 32; r += 2) rd(r, r + 1, tag);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;

    // R1: reset state
    read_all("R1");

    // R2: register 0
    wr(0, 32'hDEAD_BEEF, "R2");
    rd(0, 0, "R2");

    // fill window 7
    for (int r = 1; r < 32; r++) wr(r, 32'h7000_0000 + r, "R10");
    read_all("R7");

    // R9/R8/R7: after save, old outs visible as ins, fresh locals
    sv("R3");
    read_all("R9");
    for (int r = 16; r < 24; r++) wr(r, 32'h6000_0000 + r, "R8");
    rs("R4");
    read_all("R8");

    // R10: write with save uses the old window; read during write sees old value
    wr_en = 1; wr_idx = 5'd17; wr_data = 32'hAAAA_0017; rd_a_idx = 5'd17; save_req = 1; cyc("R10");
    rd(17, 26, "R10");
    rs("R10");
    rd(17, 9, "R10");

    // R3 down to window 1, then R5 overflow against window 0
    for (int i = 0; i < 6; i++) sv("R3");
    sv("R5");
    sv("R5");
    rd(1, 20, "R5");
    // R4 back up to 7, then R6 underflow against window 0
    for (int i = 0; i < 6; i++) rs("R4");
    rs("R6");
    rd(24, 8, "R6");

    // wrap points: make window 4 invalid only
    mask_wr_en = 1; mask_wr_data = 8'h10; cyc("R11");
    rs("R4");          // 7 -> 0
    sv("R3");          // 0 -> 7
    sv("R3");          // 7 -> 6
    sv("R3");          // 6 -> 5
    sv("R5");          // 5 -> 4 invalid

    // R11: pointer load overrides trapping save
    ptr_wr_en = 1; ptr_wr_data = 3'd5; save_req = 1; cyc("R11");
    // R11: mask load with save checks old mask (4 still invalid)
    mask_wr_en = 1; mask_wr_data = 8'h00; save_req = 1; cyc("R11");
    sv("R11");         // now 5 -> 4 allowed
    // R11: mask load marks target invalid, save same cycle still moves
    mask_wr_en = 1; mask_wr_data = 8'h08; save_req = 1; cyc("R11");
    rs("R6");          // 3 -> 4 ok? window 4 valid now
    // R12: both requests, save wins
    save_req = 1; restore_req = 1; cyc("R12");
    save_req = 1; restore_req = 1; cyc("R12");

    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      int c = int'($urandom_range(0, 9));
      rd_a_idx = 5'($urandom_range(0, 31));
      rd_b_idx = 5'($urandom_range(0, 31));
      wr_en = ($urandom_range(0, 1) == 1);
      wr_idx = 5'($urandom_range(0, 31));
      wr_data = $urandom;
      save_req = (c < 3);
      restore_req = (c >= 3 && c < 6);
      ptr_wr_en = (c == 9);
      ptr_wr_data = 3'($urandom_range(0, 7));
      mask_wr_en = (c == 8);
      mask_wr_data = 8'(1 << $urandom_range(0, 7));
      cyc("R10");
    end
    read_all("R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule